// File: doc/BRIEF.md
# DRAM calibration-pattern read redirect

This block is the device-side mode logic of a synchronous DRAM that lets a memory controller read a fixed training pattern instead of array contents. It watches the command bus each clock, recording which banks are open and how long ago the last precharge happened. It holds a pattern-mode enable and a two-bit location select. Each read is steered either to the array-read strobe or to a built-in burst generator.

A controller turns pattern mode on by writing mode register 3, selected by the bank address, with address bit 2 set. This write is refused when any bank is open or the precharge time has not yet run out. While the mode is on, only reads and the mode-register write that turns it off are accepted. Every other command is flagged as illegal and ignored. A read with auto-precharge is served like a plain read and leaves the banks alone. Reset always returns the block to normal operation.

Top module: `cal_read_redirect`

## Requirements
- R1: A mode-register-set command (`cmd`=1) with `bank`=3 and `addr[2]`=1 turns pattern mode on, subject to R2. The same command with `addr[2]`=0 turns it off. `pat_mode` shows the new state one cycle after the command. The same command to any other bank leaves the mode unchanged.
- R2: An enable is accepted only when no bank is open and at least T_PRE+1 cycles have passed since the last precharge. A precharge comes from precharge-all or from a normal-mode read with auto-precharge. A refused enable pulses `err_enable` for one cycle and leaves `pat_mode` at 0.
- R3: While pattern mode is on, read (`cmd`=2) and read with auto-precharge (`cmd`=3) never raise `arr_rd_req`. They start a pattern burst instead.
- R4: `addr[1:0]` of the accepted enable selects the pattern location, shown on `pat_loc`. These bits have no effect while pattern mode is off. On beat b of a burst, every data bit equals bit b of the pattern. Location 0 uses 8'hAA, so beat 0 is all zeros and the beats alternate. Locations 1 to 3 use PAT_LOC1 to PAT_LOC3.
- R5: A read with auto-precharge in pattern mode does not change bank state (`all_idle` stays as it was). In normal mode it closes the addressed bank and restarts the precharge timer.
- R6: In pattern mode, every command other than no-op (`cmd`=0), the two reads, and the disabling write pulses `err_illegal` one cycle later and has no effect. The illegal commands are activate (5), write (6), precharge-all (4), power-down (7), self-refresh (8), refresh (9), and any other mode-register write.
- R7: An asserted `rst_n` clears pattern mode, the location, all bank state, the flags and any burst.
- R8: With pattern mode off, a read or read with auto-precharge pulses `arr_rd_req` one cycle after the command, and a write pulses `arr_wr_req` one cycle after the command.
- R9: A redirected read raises `rd_valid` exactly RD_LAT cycles after the clock edge that samples it, and holds it for 8 cycles, one beat per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 4 | Command code: 0 nop, 1 mode-register set, 2 read, 3 read+auto-precharge, 4 precharge-all, 5 activate, 6 write, 7 power-down, 8 self-refresh, 9 refresh |
| bank | input | BA_W | Bank address; register select for mode-register set |
| addr | input | ADDR_W | Address; bits 2:0 carry the pattern-mode fields |
| arr_rd_req | output | 1 | Array read request strobe |
| arr_wr_req | output | 1 | Array write request strobe |
| pat_mode | output | 1 | Pattern mode is on |
| pat_loc | output | 2 | Selected pattern location |
| all_idle | output | 1 | No bank open and precharge time elapsed |
| err_enable | output | 1 | Enable refused because banks were not idle |
| err_illegal | output | 1 | Illegal command in pattern mode |
| rd_valid | output | 1 | Pattern burst beat valid |
| rd_data | output | DQ_W | Pattern burst data |

## Verification
The enable is tried at four moments:
- with a bank open;
- exactly T_PRE cycles after a precharge;
- one cycle later;
- right after a normal-mode auto-precharge.

These separate an open-bank check from a timer that is off by one. Bursts are read from all four locations, using both read kinds, so a wrong location decode or a wrong beat order shows up as wrong data. The full set of illegal commands is sent in pattern mode, followed by a read. This separates commands that are only flagged from commands that also leak into bank state or the mode. A seeded random command stream, compared against a bench model, then mixes all commands in both modes.

// File: rtl/cal_rd_pkg.sv
package cal_rd_pkg;
   typedef enum logic [3:0] {
      C_NOP  = 4'd0,
      C_MRS  = 4'd1,
      C_RD   = 4'd2,
      C_RDA  = 4'd3,
      C_PREA = 4'd4,
      C_ACT  = 4'd5,
      C_WR   = 4'd6,
      C_PDE  = 4'd7,
      C_SRE  = 4'd8,
      C_REF  = 4'd9
   } cmd_e;

   localparam int         BURST_LEN = 8;
   localparam logic [7:0] LOC0_PAT  = 8'hAA;
endpackage

// File: rtl/cal_bank_tracker.sv
module cal_bank_tracker #(
   parameter int BA_W  = 3,
   parameter int T_PRE = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            act_i,
   input  logic [BA_W-1:0] ba_i,
   input  logic            pre_all_i,
   input  logic            auto_pre_i,
   output logic            idle_o
);
   localparam int NB = 1 << BA_W;
   localparam int CW = $clog2(T_PRE + 1);

   if (T_PRE < 1) begin : g_bad_tpre
      $error("T_PRE must be at least 1");
   end

   logic [NB-1:0] open_q;
   logic [CW-1:0] tmr_q;

   for (genvar g = 0; g < NB; g++) begin : g_bank
      logic open_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            open_r <= 1'b0;
         else if (pre_all_i || (auto_pre_i && ba_i == BA_W'(g)))
            open_r <= 1'b0;
         else if (act_i && ba_i == BA_W'(g))
            open_r <= 1'b1;
      end
      assign open_q[g] = open_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tmr_q <= '0;
      else if (pre_all_i || auto_pre_i)
         tmr_q <= CW'(T_PRE);
      else if (tmr_q != '0)
         tmr_q <= tmr_q - 1'b1;
   end

   assign idle_o = (open_q == '0) && (tmr_q == '0);

   assert_precharge_blocks_idle_R2 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (pre_all_i || auto_pre_i) |=> !idle_o);

   assert_activate_blocks_idle_R2 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (act_i && !pre_all_i) |=> !idle_o);
endmodule

// File: rtl/cal_mode_ctrl.sv
module cal_mode_ctrl
   import cal_rd_pkg::*;
#(
   parameter int BA_W   = 3,
   parameter int ADDR_W = 14,
   parameter int MR_SEL = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_e              cmd_i,
   input  logic [BA_W-1:0]   ba_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              idle_i,
   output logic              act_o,
   output logic              pre_all_o,
   output logic              auto_pre_o,
   output logic              pat_rd_o,
   output logic              mode_o,
   output logic [1:0]        loc_o,
   output logic              arr_rd_o,
   output logic              arr_wr_o,
   output logic              err_en_o,
   output logic              err_ill_o
);
   if (ADDR_W < 3) begin : g_bad_aw
      $error("ADDR_W must be at least 3");
   end

   logic       mode_q;
   logic [1:0] loc_q;
   logic       mr3_hit;
   logic       set_on, set_off, ill, rej, rd, wr;

   assign mr3_hit = (cmd_i == C_MRS) && (ba_i == BA_W'(MR_SEL));

   always_comb begin
      act_o      = 1'b0;
      pre_all_o  = 1'b0;
      auto_pre_o = 1'b0;
      pat_rd_o   = 1'b0;
      set_on     = 1'b0;
      set_off    = 1'b0;
      ill        = 1'b0;
      rej        = 1'b0;
      rd         = 1'b0;
      wr         = 1'b0;
      if (mode_q) begin
         case (cmd_i)
            C_NOP:       ;
            C_RD, C_RDA: pat_rd_o = 1'b1;
            C_MRS: begin
               if (mr3_hit && !addr_i[2]) set_off = 1'b1;
               else                       ill     = 1'b1;
            end
            default:     ill = 1'b1;
         endcase
      end else begin
         case (cmd_i)
            C_RD:   rd = 1'b1;
            C_RDA: begin
               rd         = 1'b1;
               auto_pre_o = 1'b1;
            end
            C_WR:   wr        = 1'b1;
            C_ACT:  act_o     = 1'b1;
            C_PREA: pre_all_o = 1'b1;
            C_MRS: begin
               if (mr3_hit && addr_i[2]) begin
                  if (idle_i) set_on = 1'b1;
                  else        rej    = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= 1'b0;
         loc_q     <= 2'd0;
         arr_rd_o  <= 1'b0;
         arr_wr_o  <= 1'b0;
         err_en_o  <= 1'b0;
         err_ill_o <= 1'b0;
      end else begin
         if (set_on) begin
            mode_q <= 1'b1;
            loc_q  <= addr_i[1:0];
         end else if (set_off) begin
            mode_q <= 1'b0;
         end
         arr_rd_o  <= rd;
         arr_wr_o  <= wr;
         err_en_o  <= rej;
         err_ill_o <= ill;
      end
   end

   assign mode_o = mode_q;
   assign loc_o  = loc_q;

   assert_enable_needs_idle_R2 : assert property (
      @(posedge clk) disable iff (!rst_n)
      $rose(mode_q) |-> $past(idle_i));

   assert_refused_enable_R2 : assert property (
      @(posedge clk) disable iff (!rst_n)
      err_en_o |-> !mode_q);

   assert_no_array_read_in_mode_R3 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (mode_q && (cmd_i == C_RD || cmd_i == C_RDA)) |=> !arr_rd_o);

   assert_illegal_no_effect_R6 : assert property (
      @(posedge clk) disable iff (!rst_n)
      err_ill_o |-> ($stable(mode_q) && $stable(loc_q)));

   assert_mode_blocks_bank_ops_R6 : assert property (
      @(posedge clk) disable iff (!rst_n)
      mode_q |-> !(act_o || pre_all_o || auto_pre_o));
endmodule

// File: rtl/cal_pattern_gen.sv
module cal_pattern_gen
   import cal_rd_pkg::*;
#(
   parameter int         DQ_W     = 8,
   parameter int         RD_LAT   = 5,
   parameter logic [7:0] PAT_LOC1 = 8'h0F,
   parameter logic [7:0] PAT_LOC2 = 8'h66,
   parameter logic [7:0] PAT_LOC3 = 8'hE1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [1:0]      loc_i,
   output logic            valid_o,
   output logic [DQ_W-1:0] data_o
);
   localparam int BTW = $clog2(BURST_LEN);

   if (RD_LAT < 1 || RD_LAT > 32) begin : g_bad_lat
      $error("RD_LAT must lie in 1..32");
   end
   if (DQ_W < 1) begin : g_bad_dq
      $error("DQ_W must be at least 1");
   end

   logic [RD_LAT-1:0] dly_v;
   logic [1:0]        dly_l [RD_LAT];

   for (genvar g = 0; g < RD_LAT; g++) begin : g_stage
      logic       v_r;
      logic [1:0] l_r;
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_r <= 1'b0;
               l_r <= 2'd0;
            end else begin
               v_r <= start_i;
               l_r <= loc_i;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_r <= 1'b0;
               l_r <= 2'd0;
            end else begin
               v_r <= dly_v[g-1];
               l_r <= dly_l[g-1];
            end
         end
      end
      assign dly_v[g] = v_r;
      assign dly_l[g] = l_r;
   end

   logic           busy_q;
   logic [BTW-1:0] beat_q;
   logic [1:0]     bl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         beat_q <= '0;
         bl_q   <= 2'd0;
      end else if (dly_v[RD_LAT-1]) begin
         busy_q <= 1'b1;
         beat_q <= '0;
         bl_q   <= dly_l[RD_LAT-1];
      end else if (busy_q) begin
         if (beat_q == BTW'(BURST_LEN - 1)) busy_q <= 1'b0;
         beat_q <= beat_q + 1'b1;
      end
   end

   function automatic logic [7:0] pat_of(input logic [1:0] l);
      case (l)
         2'd0:    return LOC0_PAT;
         2'd1:    return PAT_LOC1;
         2'd2:    return PAT_LOC2;
         default: return PAT_LOC3;
      endcase
   endfunction

   logic [7:0] cur_pat;
   assign cur_pat = pat_of(bl_q);
   assign valid_o = busy_q;
   assign data_o  = busy_q ? {DQ_W{cur_pat[beat_q]}} : '0;

   assert_burst_eight_beats_R9 : assert property (
      @(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> ($past(beat_q) == BTW'(BURST_LEN - 1)));

   assert_start_after_latency_R9 : assert property (
      @(posedge clk) disable iff (!rst_n)
      dly_v[RD_LAT-1] |=> (busy_q && beat_q == '0));
endmodule

// File: rtl/cal_read_redirect.sv
module cal_read_redirect
   import cal_rd_pkg::*;
#(
   parameter int         BA_W     = 3,
   parameter int         ADDR_W   = 14,
   parameter int         DQ_W     = 8,
   parameter int         RD_LAT   = 5,
   parameter int         T_PRE    = 4,
   parameter int         MR_SEL   = 3,
   parameter logic [7:0] PAT_LOC1 = 8'h0F,
   parameter logic [7:0] PAT_LOC2 = 8'h66,
   parameter logic [7:0] PAT_LOC3 = 8'hE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        cmd,
   input  logic [BA_W-1:0]   bank,
   input  logic [ADDR_W-1:0] addr,
   output logic              arr_rd_req,
   output logic              arr_wr_req,
   output logic              pat_mode,
   output logic [1:0]        pat_loc,
   output logic              all_idle,
   output logic              err_enable,
   output logic              err_illegal,
   output logic              rd_valid,
   output logic [DQ_W-1:0]   rd_data
);
   if (MR_SEL >= (1 << BA_W)) begin : g_bad_sel
      $error("MR_SEL does not fit the bank address");
   end

   cmd_e cmd_t;
   logic act, pre_all, auto_pre, pat_rd;

   assign cmd_t = cmd_e'(cmd);

   cal_bank_tracker #(.BA_W(BA_W), .T_PRE(T_PRE)) u_banks (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_i      (act),
      .ba_i       (bank),
      .pre_all_i  (pre_all),
      .auto_pre_i (auto_pre),
      .idle_o     (all_idle)
   );

   cal_mode_ctrl #(.BA_W(BA_W), .ADDR_W(ADDR_W), .MR_SEL(MR_SEL)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_i      (cmd_t),
      .ba_i       (bank),
      .addr_i     (addr),
      .idle_i     (all_idle),
      .act_o      (act),
      .pre_all_o  (pre_all),
      .auto_pre_o (auto_pre),
      .pat_rd_o   (pat_rd),
      .mode_o     (pat_mode),
      .loc_o      (pat_loc),
      .arr_rd_o   (arr_rd_req),
      .arr_wr_o   (arr_wr_req),
      .err_en_o   (err_enable),
      .err_ill_o  (err_illegal)
   );

   cal_pattern_gen #(
      .DQ_W(DQ_W), .RD_LAT(RD_LAT),
      .PAT_LOC1(PAT_LOC1), .PAT_LOC2(PAT_LOC2), .PAT_LOC3(PAT_LOC3)
   ) u_pat (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (pat_rd),
      .loc_i   (pat_loc),
      .valid_o (rd_valid),
      .data_o  (rd_data)
   );

   assert_no_array_write_in_mode_R6 : assert property (
      @(posedge clk) disable iff (!rst_n)
      pat_mode |=> !arr_wr_req);

   assert_flags_exclusive_R2 : assert property (
      @(posedge clk) disable iff (!rst_n)
      $countones({err_enable, err_illegal, arr_rd_req, arr_wr_req}) <= 1);
endmodule

// File: tb/tb_cal_read_redirect.sv
module tb_cal_read_redirect;
   import cal_rd_pkg::*;

   localparam int         BA_W   = 3;
   localparam int         ADDR_W = 14;
   localparam int         DQ_W   = 8;
   localparam int         RD_LAT = 5;
   localparam int         T_PRE  = 4;
   localparam logic [7:0] P1 = 8'h0F;
   localparam logic [7:0] P2 = 8'h66;
   localparam logic [7:0] P3 = 8'hE1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [3:0]        cmd = 4'd0;
   logic [BA_W-1:0]   bank = '0;
   logic [ADDR_W-1:0] addr = '0;
   logic              arr_rd_req, arr_wr_req, pat_mode, all_idle;
   logic              err_enable, err_illegal, rd_valid;
   logic [1:0]        pat_loc;
   logic [DQ_W-1:0]   rd_data;

   cal_read_redirect #(
      .BA_W(BA_W), .ADDR_W(ADDR_W), .DQ_W(DQ_W), .RD_LAT(RD_LAT),
      .T_PRE(T_PRE), .MR_SEL(3), .PAT_LOC1(P1), .PAT_LOC2(P2), .PAT_LOC3(P3)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .addr(addr),
      .arr_rd_req(arr_rd_req), .arr_wr_req(arr_wr_req), .pat_mode(pat_mode),
      .pat_loc(pat_loc), .all_idle(all_idle), .err_enable(err_enable),
      .err_illegal(err_illegal), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   always #10 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always @(posedge clk) cyc <= cyc + 1;

   bit         m_mode = 1'b0;
   logic [1:0] m_loc  = 2'd0;
   bit [7:0]   m_open = '0;
   int         m_pre  = -100;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   function automatic logic pat_bit(input logic [1:0] l, input int b);
      case (l)
         2'd0:    return logic'(b % 2);
         2'd1:    return P1[b];
         2'd2:    return P2[b];
         default: return P3[b];
      endcase
   endfunction

   task automatic do_reset();
      cmd   = C_NOP;
      rst_n = 1'b0;
      m_mode = 1'b0; m_loc = 2'd0; m_open = '0; m_pre = -100;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Drives one command at a falling edge, checks the registered results
   // at the next falling edge, predicting them from the bench model.
   task automatic do_cmd(input cmd_e c, input int b, input int a);
      int   e      = cyc + 1;
      bit   idle_m = (m_open == 0) && (e - m_pre >= T_PRE + 1);
      bit   mr3    = (c == C_MRS) && (b == 3);
      logic er = 0, ew = 0, ee = 0, ei = 0;
      if (m_mode) begin
         case (c)
            C_NOP, C_RD, C_RDA: ;
            C_MRS: if (mr3 && a[2] == 1'b0) m_mode = 1'b0; else ei = 1;
            default: ei = 1;
         endcase
      end else begin
         case (c)
            C_RD:  er = 1;
            C_RDA: begin er = 1; m_open[b] = 1'b0; m_pre = e; end
            C_WR:  ew = 1;
            C_ACT: m_open[b] = 1'b1;
            C_PREA: begin m_open = '0; m_pre = e; end
            C_MRS: if (mr3 && a[2]) begin
                      if (idle_m) begin m_mode = 1'b1; m_loc = a[1:0]; end
                      else ee = 1;
                   end
            default: ;
         endcase
      end
      cmd  = c;
      bank = BA_W'(b);
      addr = ADDR_W'(a);
      @(posedge clk);
      @(negedge clk);
      check("R3 R8 arr_rd_req", arr_rd_req, er);
      check("R8 arr_wr_req", arr_wr_req, ew);
      check("R2 err_enable", err_enable, ee);
      check("R6 err_illegal", err_illegal, ei);
      check("R1 pat_mode", pat_mode, m_mode);
      if (m_mode) check("R4 pat_loc", pat_loc, m_loc);
      check("R5 all_idle", all_idle, (m_open == 0) && (e - m_pre >= T_PRE));
      cmd = C_NOP;
   endtask

   // Called right after do_cmd of a redirected read.
   task automatic chk_burst(input logic [1:0] l);
      for (int i = 1; i <= RD_LAT + 8; i++) begin
         bit v;
         @(negedge clk);
         v = (i >= RD_LAT) && (i < RD_LAT + 8);
         check("R9 rd_valid timing", rd_valid, v);
         if (v) check("R4 rd_data beat", rd_data, {DQ_W{pat_bit(l, i - RD_LAT)}});
      end
      @(negedge clk);
      check("R9 rd_valid ends", rd_valid, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED));
      do_reset();
      // R7 reset state
      check("R7 reset pat_mode", pat_mode, 0);
      check("R7 reset all_idle", all_idle, 1);
      check("R7 reset rd_valid", rd_valid, 0);
      check("R7 reset flags", {err_enable, err_illegal, arr_rd_req, arr_wr_req}, 0);

      // R8 normal path
      do_cmd(C_RD, 0, 0);
      do_cmd(C_WR, 1, 0);
      do_cmd(C_RDA, 4, 0);
      // R4 location bits are don't-care with A2 clear
      do_cmd(C_MRS, 3, 3);

      // R2 enable preconditions
      repeat (T_PRE + 1) do_cmd(C_NOP, 0, 0);
      do_cmd(C_ACT, 2, 0);
      do_cmd(C_MRS, 3, 4);
      check("R2 refused with open bank", pat_mode, 0);
      do_cmd(C_PREA, 0, 0);
      repeat (T_PRE - 1) do_cmd(C_NOP, 0, 0);
      do_cmd(C_MRS, 3, 4);
      check("R2 refused at T_PRE edge", pat_mode, 0);
      do_cmd(C_MRS, 3, 4);
      check("R2 accepted after T_PRE", pat_mode, 1);

      // R3 R9 redirected reads, location 0
      do_cmd(C_RD, 0, 0);
      chk_burst(2'd0);
      do_cmd(C_RDA, 5, 0);
      check("R5 RDA keeps banks idle", all_idle, 1);
      chk_burst(2'd0);

      // R6 illegal commands in pattern mode
      do_cmd(C_ACT, 1, 0);
      do_cmd(C_WR, 1, 0);
      do_cmd(C_PREA, 0, 0);
      do_cmd(C_PDE, 0, 0);
      do_cmd(C_SRE, 0, 0);
      do_cmd(C_REF, 0, 0);
      do_cmd(C_MRS, 0, 0);
      do_cmd(C_MRS, 3, 5);
      check("R6 activate had no effect", all_idle, 1);
      do_cmd(C_RD, 0, 0);
      chk_burst(2'd0);

      // R4 locations 1..3, R1 disable
      for (int l = 1; l < 4; l++) begin
         do_cmd(C_MRS, 3, 0);
         do_cmd(C_MRS, 3, 4 | l);
         do_cmd(C_RDA, l, 0);
         chk_burst(2'(l));
      end

      // R5 normal-mode auto-precharge restarts timer
      do_cmd(C_MRS, 3, 0);
      do_cmd(C_ACT, 1, 0);
      do_cmd(C_RDA, 1, 0);
      do_cmd(C_MRS, 3, 4);
      check("R5 RDA restarts precharge timer", pat_mode, 0);

      // R7 reset inside pattern mode
      repeat (T_PRE + 1) do_cmd(C_NOP, 0, 0);
      do_cmd(C_MRS, 3, 6);
      check("R7 mode on before reset", pat_mode, 1);
      do_reset();
      check("R7 reset clears mode", pat_mode, 0);
      do_cmd(C_RD, 0, 0);

      // seeded random mix
      for (int k = 0; k < 400; k++) begin
         int r = $urandom_range(0, 11);
         int b = $urandom_range(0, 7);
         int a = $urandom_range(0, 7);
         case (r)
            0, 1, 2: do_cmd(C_MRS, ($urandom_range(0, 3) != 0) ? 3 : b, a);
            3:  do_cmd(C_RD, b, a);
            4:  do_cmd(C_RDA, b, a);
            5:  do_cmd(C_PREA, b, a);
            6:  do_cmd(C_ACT, b, a);
            7:  do_cmd(C_WR, b, a);
            8:  do_cmd(C_PDE, b, a);
            9:  do_cmd(C_SRE, b, a);
            10: do_cmd(C_REF, b, a);
            default: do_cmd(C_NOP, b, a);
         endcase
      end
      finish_run();
   end
endmodule